// File: doc/BRIEF.md
# Prescaled Up/Down Timebase Counter

This block is the time base of a timer. A wide counter steps once per prescaler tick. It wraps against an auto-reload value in one of three ways: counting upward, counting downward, or rising and falling in a triangle that is symmetric about its centre. Each wrap or turning point is a cycle event. A repetition counter lets a chosen number of cycle events pass before it raises an update event. The update event is the point at which the preloaded prescaler, reload and repetition values take effect.

Software drives the block through a write-only register port. The port sets the control bits and the three preload values, and it issues commands to force an update and to clear the interrupt flag. The outputs are:
- the live count;
- the direction;
- a one-cycle update pulse;
- a sticky interrupt flag;
- the run state, which one-pulse mode clears by itself once the repetition count is used up.

Top module: `tmr_timebase`

## Requirements
- R1: After reset the count is 0, the direction is up (0), the update pulse and interrupt flag are low, and the counter is stopped. The prescaler divider is 0, the reload value is all ones and the repetition value is 0.
- R2: In up mode (mode code 0), each tick adds one to the count. A tick at the reload value ARR returns the count to 0 and is a cycle event, so one period is ARR+1 ticks. The direction output is 0.
- R3: In down mode (mode code 1), each tick subtracts one from the count. A tick at 0 reloads ARR and is a cycle event. The direction output is 1.
- R4: In centre mode (mode code 2), the count rises to ARR and then falls to 0. The tick taken at ARR and the tick taken at 0 are both cycle events and reverse the direction. The direction output is 1 while the count falls. With ARR = 0 every tick is a cycle event and the count stays 0.
- R5: While running, the count steps once every PSC+1 clocks, where PSC is the active 16-bit divider. It does not change in any other clock unless an update is forced.
- R6: With active repetition value REP, every (REP+1)-th cycle event is an update event. The update pulse goes high for one cycle in the clock after the tick that caused it.
- R7: New prescaler, reload and repetition values do not disturb the count in progress. The old values stay in force until the next update event or forced update.
- R8: Writing command bit 0 forces an update, whether the counter runs or not. This load happens in the same clock as the write and pulses the update output one cycle later:
  - the preloaded values are loaded;
  - the prescaler phase and the repetition count restart;
  - the count becomes ARR with direction 1 in down mode, and 0 with direction 0 otherwise.
- R9: The interrupt flag is set by every update event and stays set until command bit 1 is written. Setting wins over clearing in the same clock. A forced update also sets the flag unless the quiet-force control bit is 1.
- R10: With the one-pulse bit set, the update event that ends a repetition run clears the run bit. The count then holds.
- R11: Register addresses:
  - address 0 holds the control bits: bit 0 run, bits 2:1 mode, bit 3 one-pulse, bit 4 quiet-force;
  - address 1 holds the prescaler preload (low 16 bits);
  - address 2 holds the reload preload;
  - address 3 holds the repetition preload (low 16 bits);
  - address 4 takes commands: bit 0 forces an update, bit 1 clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Write data |
| count_o | output | 32 | Current counter value |
| dir_o | output | 1 | Direction, 1 = counting down |
| upd_evt_o | output | 1 | One-cycle update event pulse |
| irq_o | output | 1 | Sticky update interrupt flag |
| run_o | output | 1 | Counter enable state |

## Verification
A wrong prescaler phase or a wrong count shows on `count_o` within one tick. A stale repetition count or a stale shadow value shows at the next wrap, as an update pulse that comes early or is missing, or as a period of the wrong length. A wrong direction register shows at the next turning point in centre mode: the count steps away from the expected triangle. A bad flag or run state shows on `irq_o` or `run_o` in the cycle after the update that should have changed it. The sweep compares every cycle of every small configuration against closed-form expressions in the tick index, so any such fault is seen within one counter period.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_UP     = 2'd0,
    MODE_DOWN   = 2'd1,
    MODE_CENTRE = 2'd2,
    MODE_RSVD   = 2'd3
  } cnt_mode_e;

  localparam int ADDR_W   = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_PSC  = 3'd1;
  localparam logic [ADDR_W-1:0] A_ARR  = 3'd2;
  localparam logic [ADDR_W-1:0] A_REP  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd4;

  localparam int B_RUN   = 0;
  localparam int B_MODE0 = 1;
  localparam int B_OPM   = 3;
  localparam int B_QUIET = 4;
  localparam int B_FORCE = 0;
  localparam int B_CLR   = 1;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] div,
  output logic             tick_o
);

  logic [PSC_W-1:0] phase;

  // The comparison is >= so that a divider shrinking below the phase still ticks.
  function automatic logic phase_done(input logic [PSC_W-1:0] ph, input logic [PSC_W-1:0] d);
    return ph >= d;
  endfunction

  assign tick_o = run && !restart && phase_done(phase, div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (restart) begin
      phase <= '0;
    end else if (run) begin
      if (phase_done(phase, div)) phase <= '0;
      else                        phase <= phase + 1'b1;
    end
  end

endmodule

// File: rtl/tmr_updown.sv
module tmr_updown
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  cnt_mode_e        mode,
  input  logic [CNT_W-1:0] arr_cur,
  input  logic [CNT_W-1:0] arr_reload,
  input  logic             force_ld,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             cyc_evt_o
);

  typedef struct packed {
    logic             dn;
    logic [CNT_W-1:0] val;
  } step_t;

  logic [CNT_W-1:0] cnt;
  logic             dir;
  logic             bnd;
  step_t            nxt;

  // A boundary is the value at which the next tick wraps or turns around.
  function automatic logic at_boundary(input cnt_mode_e m, input logic d,
                                       input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] a);
    case (m)
      MODE_DOWN:   return c == '0;
      MODE_CENTRE: return d ? (c == '0) : (c >= a);
      default:     return c >= a;
    endcase
  endfunction

  function automatic step_t next_step(input cnt_mode_e m, input logic d, input logic b,
                                      input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] rl);
    step_t s;
    case (m)
      MODE_DOWN: begin
        s.dn  = 1'b1;
        s.val = b ? rl : c - 1'b1;
      end
      MODE_CENTRE: begin
        if (!d) begin
          s.dn  = b;
          s.val = b ? ((c == '0) ? '0 : c - 1'b1) : c + 1'b1;
        end else begin
          s.dn  = !b;
          s.val = b ? ((rl == '0) ? '0 : {{(CNT_W-1){1'b0}}, 1'b1}) : c - 1'b1;
        end
      end
      default: begin
        s.dn  = 1'b0;
        s.val = b ? '0 : c + 1'b1;
      end
    endcase
    return s;
  endfunction

  always_comb begin
    bnd = at_boundary(mode, dir, cnt, arr_cur);
    nxt = next_step(mode, dir, bnd, cnt, arr_reload);
  end

  assign cyc_evt_o = tick && bnd && !force_ld;
  assign cnt_o     = cnt;
  assign dir_o     = dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      dir <= 1'b0;
    end else if (force_ld) begin
      cnt <= (mode == MODE_DOWN) ? arr_reload : '0;
      dir <= (mode == MODE_DOWN);
    end else if (tick) begin
      cnt <= nxt.val;
      dir <= nxt.dn;
    end
  end

endmodule

// File: rtl/tmr_repeat.sv
module tmr_repeat #(
  parameter int REP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_evt,
  input  logic             force_ld,
  input  logic [REP_W-1:0] rep_load,
  output logic             upd_o
);

  logic [REP_W-1:0] remain;

  assign upd_o = cyc_evt && (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (force_ld || upd_o) begin
      remain <= rep_load;
    end else if (cyc_evt) begin
      remain <= remain - 1'b1;
    end
  end

endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PSC_W = 16,
  parameter int REP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  count_o,
  output logic              dir_o,
  output logic              upd_evt_o,
  output logic              irq_o,
  output logic              run_o
);

  // Control and shadow state
  logic             run_q, opm_q, quiet_q, flag_q, upd_q;
  logic [1:0]       mode_q;
  logic [PSC_W-1:0] psc_pre, psc_act;
  logic [CNT_W-1:0] arr_pre, arr_act;
  logic [REP_W-1:0] rep_pre;

  // Named internal events
  logic             ctrl_wr, force_cmd, clr_cmd;
  logic             tick_w, cyc_evt_w, upd_nat_w, load_w;
  logic [CNT_W-1:0] arr_reload_w;
  cnt_mode_e        mode_w;

  assign ctrl_wr   = wr_en && (wr_addr == A_CTRL);
  assign force_cmd = wr_en && (wr_addr == A_CMD) && wr_data[B_FORCE];
  assign clr_cmd   = wr_en && (wr_addr == A_CMD) && wr_data[B_CLR];
  assign mode_w    = cnt_mode_e'(mode_q);
  assign load_w    = upd_nat_w || force_cmd;
  // A reload that coincides with an update already uses the new period.
  assign arr_reload_w = load_w ? arr_pre : arr_act;

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_q),
    .restart (force_cmd),
    .div     (psc_act),
    .tick_o  (tick_w)
  );

  tmr_updown #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_w),
    .mode       (mode_w),
    .arr_cur    (arr_act),
    .arr_reload (arr_reload_w),
    .force_ld   (force_cmd),
    .cnt_o      (count_o),
    .dir_o      (dir_o),
    .cyc_evt_o  (cyc_evt_w)
  );

  tmr_repeat #(.REP_W(REP_W)) u_rep (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_evt  (cyc_evt_w),
    .force_ld (force_cmd),
    .rep_load (rep_pre),
    .upd_o    (upd_nat_w)
  );

  // Register port: control bits and preload values
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      mode_q  <= 2'd0;
      opm_q   <= 1'b0;
      quiet_q <= 1'b0;
      psc_pre <= '0;
      arr_pre <= '1;
      rep_pre <= '0;
    end else begin
      if (ctrl_wr) begin
        run_q   <= wr_data[B_RUN];
        mode_q  <= wr_data[B_MODE0 +: 2];
        opm_q   <= wr_data[B_OPM];
        quiet_q <= wr_data[B_QUIET];
      end else if (upd_nat_w && opm_q) begin
        run_q <= 1'b0;
      end
      if (wr_en && wr_addr == A_PSC) psc_pre <= wr_data[PSC_W-1:0];
      if (wr_en && wr_addr == A_ARR) arr_pre <= wr_data;
      if (wr_en && wr_addr == A_REP) rep_pre <= wr_data[REP_W-1:0];
    end
  end

  // Active values follow their preloads only at an update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_act <= '0;
      arr_act <= '1;
    end else if (load_w) begin
      psc_act <= psc_pre;
      arr_act <= arr_pre;
    end
  end

  // Update pulse and sticky flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      upd_q <= load_w;
      if (upd_nat_w || (force_cmd && !quiet_q)) flag_q <= 1'b1;
      else if (clr_cmd)                          flag_q <= 1'b0;
    end
  end

  assign upd_evt_o = upd_q;
  assign irq_o     = flag_q;
  assign run_o     = run_q;

endmodule

// File: rtl/tmr_timebase_chk.sv
module tmr_timebase_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             cyc_evt,
  input logic             upd_nat,
  input logic             force_cmd,
  input logic             clr_cmd,
  input logic             ctrl_wr,
  input logic [1:0]       mode,
  input logic             opm,
  input logic [CNT_W-1:0] count,
  input logic             dir,
  input logic             upd_evt,
  input logic             irq,
  input logic             run
);

  // R1: the cycle after a reset clock shows the idle state
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (count == '0 && !irq && !run && !upd_evt));

  // R2: an up-mode tick below the boundary adds exactly one
  assert_up_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cyc_evt && mode == 2'd0) |=> count == $past(count) + 1'b1);

  // R4: a centre-mode tick on the falling slope, away from zero, subtracts one
  assert_centre_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cyc_evt && mode == 2'd2 && dir) |=> count == $past(count) - 1'b1);

  // R5: without a tick or a forced load the count is frozen
  assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !force_cmd) |=> $stable(count));

  // R6: an update pulse follows a cycle event or a forced load
  assert_update_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_evt) |-> $past(cyc_evt || force_cmd));

  // R9: the flag is sticky until cleared
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_cmd) |=> irq);

  // R10: one-pulse mode stops at the closing update
  assert_one_pulse_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (opm && upd_nat && !ctrl_wr) |=> !run);

endmodule

bind tmr_timebase tmr_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick_w),
  .cyc_evt   (cyc_evt_w),
  .upd_nat   (upd_nat_w),
  .force_cmd (force_cmd),
  .clr_cmd   (clr_cmd),
  .ctrl_wr   (ctrl_wr),
  .mode      (mode_q),
  .opm       (opm_q),
  .count     (count_o),
  .dir       (dir_o),
  .upd_evt   (upd_evt_o),
  .irq       (irq_o),
  .run       (run_o)
);

// File: tb/tmr_timebase_test.sv
`timescale 1ns/1ps
module tmr_timebase_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] count_o;
  logic        dir_o, upd_evt_o, irq_o, run_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  tmr_timebase uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count_o(count_o), .dir_o(dir_o), .upd_evt_o(upd_evt_o), .irq_o(irq_o), .run_o(run_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Closed-form expectations after k ticks from a forced start
  function automatic int exp_cnt(input int m, input int a, input int k);
    int p;
    if (m == 1) return a - (k % (a + 1));
    if (m == 2) begin
      if (a == 0) return 0;
      p = k % (2 * a);
      return (p <= a) ? p : 2 * a - p;
    end
    return k % (a + 1);
  endfunction

  function automatic int exp_evts(input int m, input int a, input int k);
    if (m == 2) return (a == 0) ? k : ((k >= 1) ? (k - 1) / a : 0);
    return k / (a + 1);
  endfunction

  function automatic int exp_dir(input int m, input int a, input int k);
    int p;
    if (m == 1) return 1;
    if (m == 0) return 0;
    if (a == 0) return (k % 2 == 1) ? 1 : 0;
    p = k % (2 * a);
    return (k >= a + 1 && (p > a || p == 0)) ? 1 : 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int u_prev, u_now, ticks, ncyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", count_o, 0);
    chk("R1 dir", dir_o, 0);
    chk("R1 upd", upd_evt_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 run", run_o, 0);

    // Sweep: R2 up, R3 down, R4 centre, R5 prescale, R6 repetition, R9 flag set
    for (int m = 0; m < 3; m++)
      for (int ps = 0; ps < 3; ps++)
        for (int a = 0; a < 6; a += (a < 1 ? 1 : 2))
          for (int rp = 0; rp < 3; rp += 2) begin
            wr(3'd0, 32'h10 | (m << 1));          // R11 stopped, quiet force
            wr(3'd1, ps);
            wr(3'd2, a);
            wr(3'd3, rp);
            wr(3'd4, 32'h3);                      // R8 force + clear
            wr(3'd0, 32'h11 | (m << 1));          // run
            ticks = 4 * (rp + 1) * (a + 1) + 3;
            ncyc  = ticks * (ps + 1);
            u_prev = 0;
            chk("R8 start count", count_o, exp_cnt(m, a, 0));
            for (int n = 1; n <= ncyc; n++) begin
              int k;
              @(negedge clk);
              k = n / (ps + 1);
              u_now = exp_evts(m, a, k) / (rp + 1);
              chk(m == 0 ? "R2 count" : (m == 1 ? "R3 count" : "R4 count"),
                  count_o, exp_cnt(m, a, k));
              chk("R4 dir", dir_o, exp_dir(m, a, k));
              chk("R6 upd", upd_evt_o, (u_now != u_prev) ? 1 : 0);
              chk("R9 irq", irq_o, (u_now > 0) ? 1 : 0);
              chk("R5 run", run_o, 1);
              u_prev = u_now;
            end
          end

    // R10 one-pulse
    wr(3'd0, 32'h10);
    wr(3'd1, 0); wr(3'd2, 2); wr(3'd3, 1);
    wr(3'd4, 32'h3);
    wr(3'd0, 32'h19);
    repeat (5) @(negedge clk);
    chk("R10 run before end", run_o, 1);
    @(negedge clk);
    chk("R10 count at end", count_o, 0);
    chk("R10 upd at end", upd_evt_o, 1);
    chk("R10 run cleared", run_o, 0);
    repeat (3) @(negedge clk);
    chk("R10 count held", count_o, 0);

    // R9 quiet force, loud force, sticky, clear
    wr(3'd4, 32'h2);
    wr(3'd0, 32'h10);
    wr(3'd4, 32'h1);
    chk("R8 forced pulse", upd_evt_o, 1);
    chk("R9 quiet force", irq_o, 0);
    wr(3'd0, 32'h00);
    wr(3'd4, 32'h1);
    chk("R9 loud force", irq_o, 1);
    repeat (5) @(negedge clk);
    chk("R9 sticky", irq_o, 1);
    wr(3'd4, 32'h2);
    chk("R9 cleared", irq_o, 0);

    // R7 shadowed prescaler and reload
    wr(3'd0, 32'h10);
    wr(3'd1, 0); wr(3'd2, 9); wr(3'd3, 0);
    wr(3'd4, 32'h3);
    wr(3'd0, 32'h11);
    repeat (2) @(negedge clk);
    chk("R7 pre count", count_o, 2);
    wr(3'd1, 1);
    wr(3'd2, 4);
    chk("R7 count undisturbed", count_o, 6);
    repeat (3) @(negedge clk);
    chk("R7 old reload reached", count_o, 9);
    @(negedge clk);
    chk("R7 wrap", count_o, 0);
    chk("R7 upd", upd_evt_o, 1);
    repeat (2) @(negedge clk);
    chk("R7 new prescale", count_o, 1);
    repeat (6) @(negedge clk);
    chk("R7 new reload top", count_o, 4);
    repeat (2) @(negedge clk);
    chk("R7 new wrap", count_o, 0);
    chk("R7 new upd", upd_evt_o, 1);
    repeat (3) @(negedge clk);
    wr(3'd4, 32'h1);
    chk("R8 restart mid-run", count_o, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule